// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Responder

This block connects a helper microcontroller to an 8-bit processor bus that takes its interrupts in vectored form. Before the controller raises the processor's interrupt request, it presents a vector byte on its local data bus and strobes a load input. The block keeps that byte in a register.

When the processor runs its interrupt acknowledge cycle, both its I/O request and its opcode-fetch lines are low at once. While that condition holds, the block drives the stored byte onto the processor data bus. At all other times it leaves the bus floating. The processor combines this low byte with its own page register to find the handler.

Each acknowledge is also passed through a two-flop synchroniser into the system clock domain. There it becomes a single-cycle notification, which tells the controller it can drop the interrupt request. The request line itself is not part of this block.

Top module: `irq_vector_responder`

## Requirements
- R1: After reset the stored vector is 0xFF, the bus output enable is low and the notification pulse is low.
- R2: When the load strobe is high at a rising clock edge, the controller data byte is stored and is the value supplied on the next acknowledge.
- R3: Without a load strobe the stored vector keeps its value, so repeated acknowledges return the same byte.
- R4: While both active-low request and fetch inputs are low, the output enable is high and the processor data bus carries the stored vector, combinationally with no clock delay.
- R5: When either the request input or the fetch input is high, the output enable is low and the bus is released.
- R6: An acknowledge that starts between two clock edges produces a notification pulse that is high for exactly one clock cycle, starting at the second rising edge after the acknowledge begins.
- R7: Each acknowledge produces exactly one pulse, however long it lasts. Only the request input low, or only the fetch input low, produces no pulse.
- R8: While reset is asserted the output enable stays low even during an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_data_i | input | 8 | Vector byte from the controller |
| vec_load_i | input | 1 | Active-high load strobe for the vector |
| iorq_n | input | 1 | Processor I/O request, active low |
| m1_n | input | 1 | Processor opcode-fetch cycle, active low |
| cpu_data | inout | 8 | Processor data bus, driven only during acknowledge |
| cpu_data_o | output | 8 | Value presented on the processor bus when driven |
| cpu_data_oe | output | 1 | High while the block drives the processor bus |
| ack_pulse_o | output | 1 | Single-cycle acknowledge notification to the controller |

## Verification
A corrupted vector register shows up on the very next acknowledge as a wrong byte on the bus. The bench therefore loads and reads back all 256 byte values, and it acknowledges some of them twice. A broken decode of the request and fetch inputs shows as the output enable being set for a single low input, and the bench checks every input combination. A faulty synchroniser or edge detector moves the notification away from the second edge, widens it, or repeats it during a long acknowledge. The bench catches each of these within three clock cycles of the acknowledge starting.

// File: rtl/irq_vector_responder.sv
module irq_vector_responder #(
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] RESET_VEC = '1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] vec_data_i,
  input  logic             vec_load_i,
  input  logic             iorq_n,
  input  logic             m1_n,
  inout  wire  [VEC_W-1:0] cpu_data,
  output logic [VEC_W-1:0] cpu_data_o,
  output logic             cpu_data_oe,
  output logic             ack_pulse_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [VEC_W-1:0]       vec_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ack_d;
  logic                   ack_raw;

  assign ack_raw = ~iorq_n & ~m1_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= RESET_VEC;
    else if (vec_load_i) vec_q <= vec_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      ack_d  <= 1'b0;
    end else begin
      sync_q <= {sync_q[LAST-1:0], ack_raw};
      ack_d  <= sync_q[LAST];
    end
  end

  assign ack_pulse_o = sync_q[LAST] & ~ack_d;
  assign cpu_data_oe = ack_raw & rst_n;
  assign cpu_data_o  = vec_q;
  assign cpu_data    = cpu_data_oe ? vec_q : {VEC_W{1'bz}};

  a_r2_load_stores: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load_i |=> vec_q == $past(vec_data_i));

  a_r3_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_load_i |=> $stable(vec_q));

  a_r6_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse_o |=> !ack_pulse_o);

  a_r7_pulse_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse_o |-> $past(sync_q[0]));

  always_comb begin
    a_r8_float_in_reset: assert (rst_n || !cpu_data_oe);
  end
endmodule

// File: tb/irq_vector_responder_tb.sv
module irq_vector_responder_tb_top;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] vec_data_i = '0;
  logic       vec_load_i = 1'b0;
  logic       iorq_n = 1'b1;
  logic       m1_n = 1'b1;
  wire  [7:0] cpu_data;
  logic [7:0] cpu_data_o;
  logic       cpu_data_oe;
  logic       ack_pulse_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  irq_vector_responder dut_i (
    .clk(clk), .rst_n(rst_n), .vec_data_i(vec_data_i), .vec_load_i(vec_load_i),
    .iorq_n(iorq_n), .m1_n(m1_n), .cpu_data(cpu_data), .cpu_data_o(cpu_data_o),
    .cpu_data_oe(cpu_data_oe), .ack_pulse_o(ack_pulse_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_vec(input logic [7:0] v);
    @(negedge clk);
    vec_data_i = v;
    vec_load_i = 1'b1;
    @(negedge clk);
    vec_load_i = 1'b0;
    vec_data_i = ~v;
  endtask

  task automatic acknowledge(input logic [7:0] exp, input int len, input string req);
    int pulses;
    pulses = 0;
    @(negedge clk);
    iorq_n = 1'b0;
    m1_n = 1'b0;
    #1;
    check(cpu_data_oe == 1'b1, "R4", int'(cpu_data_oe), 1);
    check(cpu_data == exp && cpu_data_o == exp, req, int'(cpu_data), int'(exp));
    for (int c = 1; c <= len; c++) begin
      @(negedge clk);
      if (c == 2) check(ack_pulse_o == 1'b1, "R6", int'(ack_pulse_o), 1);
      else if (c < 2) check(ack_pulse_o == 1'b0, "R6", int'(ack_pulse_o), 0);
      if (ack_pulse_o) pulses++;
    end
    iorq_n = 1'b1;
    m1_n = 1'b1;
    #1;
    check(cpu_data_oe == 1'b0, "R5", int'(cpu_data_oe), 0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (ack_pulse_o) pulses++;
    end
    check(pulses == 1, "R7", pulses, 1);
  endtask

  task automatic single_low(input bit lo_iorq);
    int pulses;
    pulses = 0;
    @(negedge clk);
    iorq_n = !lo_iorq;
    m1_n = lo_iorq;
    #1;
    check(cpu_data_oe == 1'b0, "R5", int'(cpu_data_oe), 0);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (ack_pulse_o) pulses++;
    end
    iorq_n = 1'b1;
    m1_n = 1'b1;
    check(pulses == 0, "R7", pulses, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cpu_data_oe == 1'b0, "R1", int'(cpu_data_oe), 0);
    check(ack_pulse_o == 1'b0, "R1", int'(ack_pulse_o), 0);
    rst_n = 1'b1;
    acknowledge(8'hFF, 3, "R1");

    for (int v = 0; v < 256; v++) begin
      load_vec(v[7:0]);
      acknowledge(v[7:0], 3 + (v % 4), "R2");
      if (v % 16 == 5) begin
        repeat (2) @(negedge clk);
        acknowledge(v[7:0], 8, "R3");
      end
    end

    single_low(1'b1);
    single_low(1'b0);

    load_vec(8'h3C);
    @(negedge clk);
    iorq_n = 1'b0;
    m1_n = 1'b0;
    rst_n = 1'b0;
    #1;
    check(cpu_data_oe == 1'b0, "R8", int'(cpu_data_oe), 0);
    @(negedge clk);
    check(ack_pulse_o == 1'b0, "R8", int'(ack_pulse_o), 0);
    iorq_n = 1'b1;
    m1_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    acknowledge(8'hFF, 3, "R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule